// File: doc/BRIEF.md
# Paired-Priority Vectored Interrupt Controller

This controller gathers twelve interrupt sources for an 8-bit processor core and presents the core with one request line and the vector address of the winning source. Seven external pins are sampled and turned into request flags by level or edge detection. Seven single-cycle event strobes from on-chip peripherals also set flags. The serial strobes share one flag, and so do the two timer-2 strobes.

Software programs the controller through a narrow write port. Each source has its own enable bit, and a global enable gates every request. Sources are grouped into six pairs. Each pair gets a two-bit priority level, with one bit in each of two priority registers. An in-service stack of four level bits allows only a strictly higher level to nest.

The core acknowledges the vector it takes, which pushes that level onto the stack and clears edge-type flags. A return strobe pops the highest active level.

Top module: `intc_pair_prio`

## Requirements
- R1: After reset, `irq` is 0, all flags, enables, priorities, modes and in-service bits are 0, and the pin samplers hold 1.
- R2: Source index s (0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 converter, 7..11 ext2..ext6) has vector 03h+8*s for s<6 and 43h+8*(s-6) otherwise, shown on `vec` while `irq` is 1.
- R3: Write address 0 sets enables for s=0..5 from data bits 5:0 and the global enable from bit 7. Address 1 sets enables for s=6..11 from bits 5:0. A masked flag stays pending and raises `irq` once enabled.
- R4: Address 4 bit 0 (ext0) and bit 1 (ext1) select the trigger: 0 means a low level sets the flag on every sampled cycle, and 1 means only a falling edge sets it.
- R5: Address 4 bit 2 (ext2) and bit 3 (ext3) select 0 for a falling edge or 1 for a rising edge. ext4..ext6 always trigger on a rising edge. An edge of the other direction sets no flag.
- R6: Pair p holds sources p and p+6. Its level is {IP1[p], IP0[p]}, where IP0 is written at address 2 and IP1 at address 3, each from bits 5:0. The highest level wins.
- R7: Among equal levels the lower pair index wins, and within a pair source p beats source p+6.
- R8: A request is raised only if its level is above the highest in-service level.
- R9: `ack` while `irq` is 1 sets the in-service bit of the presented level and forces `irq` low on the next cycle. `ack` while `irq` is 0 is ignored.
- R10: On a taken `ack`, an edge-type flag (timer0, timer1, converter, ext2..ext6, and ext0/ext1 in edge mode) is cleared, and `flag_clr` pulses one-hot for that source in the same cycle.
- R11: Serial, timer2 and level-mode flags survive an `ack`. Writing 1s to address 5 (s=0..5, bits 5:0) or address 6 (s=6..11) clears flags, and a new set in the same cycle wins.
- R12: `reti` clears the highest set in-service bit.
- R13: An event strobe raises `irq` one cycle later. A pin change raises `irq` two cycles after the clock edge that first samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 7 | External interrupt pins ext0..ext6 |
| int_evt | input | 7 | Strobes: timer0, timer1, serial rx, serial tx, timer2 overflow, timer2 reload, converter done |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Core returns from a handler |
| irq | output | 1 | Request to the core |
| vec | output | 8 | Vector address of the presented source |
| flag_clr | output | 12 | One-hot hardware clear on acknowledge |

## Verification
The request and vector are registered. They appear one edge after a flag changes, which is one edge after a strobe or two edges after a pin sample. `flag_clr` follows `ack` in the same cycle. Configuration writes act on arbitration one edge after the write and on `irq` one edge later still. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. Shortly after each falling edge it compares `irq`, `vec` and `flag_clr` with that model, so every result is checked in the cycle it is due. Directed checks wait out these latencies before sampling.

// File: rtl/intc_pair_prio.sv
module intc_pair_prio #(
  parameter int NPAIR = 6,
  parameter int NLVL  = 4,
  parameter int NEXT  = 7,
  parameter int NEVT  = 7,
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int VW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   ext_pin,
  input  logic [NEVT-1:0]   int_evt,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              ack,
  input  logic              reti,
  output logic              irq,
  output logic [VW-1:0]     vec,
  output logic [2*NPAIR-1:0] flag_clr
);
  localparam int NSRC = 2 * NPAIR;
  localparam int IW   = $clog2(NSRC);
  localparam int PW   = $clog2(NPAIR);
  localparam int LW   = $clog2(NLVL);

  logic [NEXT-1:0]  pin_s, pin_p, fall, rise;
  logic [NSRC-1:0]  flag, en, set_v, swclr, hwclr, clrable, elig;
  logic             ea;
  logic [NPAIR-1:0] ip0, ip1;
  logic [3:0]       mode;
  logic [NLVL-1:0]  ins, ins_n;
  logic             irq_q, take;
  logic [VW-1:0]    vec_q;
  logic [IW-1:0]    win_q;

  logic             found, busy, req_c;
  logic [LW-1:0]    best_lv, top_lv, win_lv;
  logic [IW-1:0]    best_ix;
  logic [PW-1:0]    win_pr;

  assign fall = pin_p & ~pin_s;
  assign rise = ~pin_p & pin_s;

  assign set_v[0]  = mode[0] ? fall[0] : ~pin_s[0];
  assign set_v[1]  = int_evt[0];
  assign set_v[2]  = mode[1] ? fall[1] : ~pin_s[1];
  assign set_v[3]  = int_evt[1];
  assign set_v[4]  = int_evt[2] | int_evt[3];
  assign set_v[5]  = int_evt[4] | int_evt[5];
  assign set_v[6]  = int_evt[6];
  assign set_v[7]  = mode[2] ? rise[2] : fall[2];
  assign set_v[8]  = mode[3] ? rise[3] : fall[3];
  assign set_v[9]  = rise[4];
  assign set_v[10] = rise[5];
  assign set_v[11] = rise[6];

  assign clrable = {6'h3F, 2'b00, 1'b1, mode[1], 1'b1, mode[0]};

  always_comb begin
    swclr = '0;
    if (wr_en && wr_addr == 3'd5) swclr[NPAIR-1:0]    = wr_data[NPAIR-1:0];
    if (wr_en && wr_addr == 3'd6) swclr[NSRC-1:NPAIR] = wr_data[NPAIR-1:0];
  end

  assign take    = ack & irq_q;
  assign win_pr  = (win_q >= IW'(NPAIR)) ? PW'(win_q - IW'(NPAIR)) : PW'(win_q);
  assign win_lv  = {ip1[win_pr], ip0[win_pr]};
  assign hwclr   = take ? ((NSRC'(1) << win_q) & clrable) : '0;
  assign flag_clr = hwclr;
  assign elig    = flag & en & {NSRC{ea}};

  always_comb begin
    found   = 1'b0;
    best_lv = '0;
    best_ix = '0;
    for (int k = 0; k < NSRC; k++) begin
      logic [PW-1:0] p;
      logic [IW-1:0] ix;
      logic [LW-1:0] lv;
      p  = PW'(k >> 1);
      ix = k[0] ? IW'((k >> 1) + NPAIR) : IW'(k >> 1);
      lv = {ip1[p], ip0[p]};
      if (elig[ix] && (!found || lv > best_lv)) begin
        found   = 1'b1;
        best_lv = lv;
        best_ix = ix;
      end
    end
  end

  always_comb begin
    busy   = 1'b0;
    top_lv = '0;
    for (int l = 0; l < NLVL; l++)
      if (ins[l]) begin
        busy   = 1'b1;
        top_lv = LW'(l);
      end
  end

  assign req_c = found && (!busy || best_lv > top_lv);

  always_comb begin
    ins_n = ins;
    if (reti && busy) ins_n[top_lv] = 1'b0;
    if (take)         ins_n[win_lv] = 1'b1;
  end

  function automatic logic [VW-1:0] vaddr(input logic [IW-1:0] s);
    if (s < IW'(NPAIR)) return VW'(8'h03 + 8 * int'(s));
    return VW'(8'h43 + 8 * (int'(s) - NPAIR));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s <= '1;
      pin_p <= '1;
      flag  <= '0;
      en    <= '0;
      ea    <= 1'b0;
      ip0   <= '0;
      ip1   <= '0;
      mode  <= '0;
      ins   <= '0;
      irq_q <= 1'b0;
      vec_q <= '0;
      win_q <= '0;
    end else begin
      pin_s <= ext_pin;
      pin_p <= pin_s;
      flag  <= (flag & ~swclr & ~hwclr) | set_v;
      ins   <= ins_n;
      irq_q <= take ? 1'b0 : req_c;
      vec_q <= vaddr(best_ix);
      win_q <= best_ix;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin en[NPAIR-1:0] <= wr_data[NPAIR-1:0]; ea <= wr_data[7]; end
          3'd1: en[NSRC-1:NPAIR] <= wr_data[NPAIR-1:0];
          3'd2: ip0  <= wr_data[NPAIR-1:0];
          3'd3: ip1  <= wr_data[NPAIR-1:0];
          3'd4: mode <= wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  assign irq = irq_q;
  assign vec = vec_q;
endmodule

// File: rtl/intc_pair_prio_chk.sv
module intc_pair_prio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ack,
  input logic        reti,
  input logic        irq,
  input logic [7:0]  vec,
  input logic [11:0] flag_clr,
  input logic        ea,
  input logic [3:0]  ins
);
  p_vec_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec[2:0] == 3'd3 && (vec <= 8'h2B || (vec >= 8'h43 && vec <= 8'h6B))));

  p_ea_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ea |=> !irq);

  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> !irq);

  p_ack_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (ins != 4'd0));

  p_clr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr));

  p_clr_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> (ack && irq));

  p_keep_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!flag_clr[4] && !flag_clr[5]));

  p_pop_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && ins != 4'd0) |=> ($countones(ins) == $countones($past(ins)) - 1));
endmodule

bind intc_pair_prio intc_pair_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .irq(irq), .vec(vec),
  .flag_clr(flag_clr), .ea(ea), .ins(ins)
);

// File: tb/tb_intc_pair_prio.sv
`timescale 1ns/1ps
module tb_intc_pair_prio;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] ext_pin = 7'h7F;
  logic [6:0] int_evt = '0;
  logic wr_en = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic irq;
  logic [7:0] vec;
  logic [11:0] flag_clr;

  int errors = 0, checks = 0, cycles = 0;
  bit run = 1'b0;
  logic [11:0] got_clr;

  always #2 clk = ~clk;

  intc_pair_prio dut (.clk, .rst_n, .ext_pin, .int_evt, .wr_en, .wr_addr, .wr_data,
                      .ack, .reti, .irq, .vec, .flag_clr);

  // behavioural reference
  bit m_flag[12], m_en[12], m_ip0[6], m_ip1[6], m_mode[4], m_ins[4];
  bit m_ea, m_irq;
  bit m_ps[7], m_pp[7];
  int m_win, m_vec;

  function automatic int vaddr(int s);
    return (s < 6) ? 3 + 8 * s : 'h43 + 8 * (s - 6);
  endfunction
  function automatic int plev(int p);
    return 2 * m_ip1[p] + m_ip0[p];
  endfunction
  function automatic bit hw_ok(int s);
    case (s)
      0: return m_mode[0];
      2: return m_mode[1];
      4, 5: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  int a_top, a_win, a_lv, a_s;
  bit a_take, a_set[12];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) begin m_flag[i] = 0; m_en[i] = 0; end
      for (int i = 0; i < 6; i++) begin m_ip0[i] = 0; m_ip1[i] = 0; end
      for (int i = 0; i < 4; i++) begin m_mode[i] = 0; m_ins[i] = 0; end
      for (int i = 0; i < 7; i++) begin m_ps[i] = 1; m_pp[i] = 1; end
      m_ea = 0; m_irq = 0; m_win = 0; m_vec = 3;
    end else begin
      a_top = -1;
      for (int l = 0; l < 4; l++) if (m_ins[l]) a_top = l;
      a_win = -1; a_lv = -1;
      for (int l = 3; l >= 0; l--)
        for (int p = 0; p < 6; p++)
          for (int m = 0; m < 2; m++) begin
            a_s = p + 6 * m;
            if (a_win < 0 && m_ea && m_en[a_s] && m_flag[a_s] && plev(p) == l) begin
              a_win = a_s; a_lv = l;
            end
          end
      a_take = ack && m_irq;
      for (int i = 0; i < 12; i++) a_set[i] = 0;
      a_set[0]  = m_mode[0] ? (m_pp[0] && !m_ps[0]) : !m_ps[0];
      a_set[1]  = int_evt[0];
      a_set[2]  = m_mode[1] ? (m_pp[1] && !m_ps[1]) : !m_ps[1];
      a_set[3]  = int_evt[1];
      a_set[4]  = int_evt[2] || int_evt[3];
      a_set[5]  = int_evt[4] || int_evt[5];
      a_set[6]  = int_evt[6];
      a_set[7]  = m_mode[2] ? (!m_pp[2] && m_ps[2]) : (m_pp[2] && !m_ps[2]);
      a_set[8]  = m_mode[3] ? (!m_pp[3] && m_ps[3]) : (m_pp[3] && !m_ps[3]);
      for (int i = 4; i < 7; i++) a_set[i + 5] = !m_pp[i] && m_ps[i];
      if (a_take && hw_ok(m_win)) m_flag[m_win] = 0;
      if (wr_en && wr_addr == 5) for (int i = 0; i < 6; i++) if (wr_data[i]) m_flag[i] = 0;
      if (wr_en && wr_addr == 6) for (int i = 0; i < 6; i++) if (wr_data[i]) m_flag[i + 6] = 0;
      if (reti && a_top >= 0) m_ins[a_top] = 0;
      if (a_take) m_ins[plev(m_win % 6)] = 1;
      for (int i = 0; i < 12; i++) if (a_set[i]) m_flag[i] = 1;
      m_irq = !a_take && a_win >= 0 && a_lv > a_top;
      if (a_win >= 0) begin m_win = a_win; m_vec = vaddr(a_win); end
      else begin m_win = 0; m_vec = 3; end
      if (wr_en) case (wr_addr)
        0: begin for (int i = 0; i < 6; i++) m_en[i] = wr_data[i]; m_ea = wr_data[7]; end
        1: for (int i = 0; i < 6; i++) m_en[i + 6] = wr_data[i];
        2: for (int i = 0; i < 6; i++) m_ip0[i] = wr_data[i];
        3: for (int i = 0; i < 6; i++) m_ip1[i] = wr_data[i];
        4: for (int i = 0; i < 4; i++) m_mode[i] = wr_data[i];
        default: ;
      endcase
      for (int i = 0; i < 7; i++) begin m_pp[i] = m_ps[i]; m_ps[i] = ext_pin[i]; end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [11:0] e_clr;
  always @(negedge clk) begin
    #1;
    if (rst_n && run) begin
      e_clr = '0;
      if (ack && m_irq && hw_ok(m_win)) e_clr[m_win] = 1'b1;
      chk("R13 irq vs model", int'(irq), int'(m_irq));
      if (m_irq) chk("R2 vec vs model", int'(vec), m_vec);
      chk("R10 flag_clr vs model", int'(flag_clr), int'(e_clr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=%0d expected<50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic evt(input logic [6:0] b);
    @(negedge clk); int_evt = b;
    @(negedge clk); int_evt = '0;
  endtask
  task automatic pin(input int i, input logic v);
    @(negedge clk); ext_pin[i] = v;
  endtask
  task automatic do_ack();
    @(negedge clk); ack = 1; #1 got_clr = flag_clr;
    @(negedge clk); ack = 0;
  endtask
  task automatic do_reti();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask
  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; run = 1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chk("R1 flag_clr after reset", flag_clr, 0);
    wr(0, 8'hBF); wr(1, 8'h3F); settle();
    chk("R1 no pending flags", irq, 0);

    evt(7'h01);
    chk("R13 irq not yet", irq, 0);
    @(negedge clk);
    chk("R13 irq one cycle after flag", irq, 1);
    chk("R2 timer0 vector", vec, 8'h0B);
    do_ack();
    chk("R10 timer0 hw clear", got_clr, 12'h002);
    chk("R9 irq drops after ack", irq, 0);
    do_reti(); settle();
    chk("R10 timer0 flag gone", irq, 0);
    evt(7'h02); settle();
    chk("R12 level0 popped, timer1 served", vec, 8'h1B);
    do_ack(); do_reti();

    evt(7'h04); settle();
    chk("R2 serial vector", vec, 8'h23);
    do_ack();
    chk("R11 serial not hw cleared", got_clr, 0);
    do_reti(); settle();
    chk("R11 serial still pending", irq, 1);
    wr(5, 8'h10); settle();
    chk("R11 sw clear serial", irq, 0);

    pin(0, 0); pin(0, 0); pin(0, 1); settle();
    chk("R4 level ext0 vector", vec, 8'h03);
    do_ack();
    chk("R4 level ext0 no hw clear", got_clr, 0);
    do_reti(); settle();
    chk("R11 level flag stays", irq, 1);
    wr(5, 8'h01); settle();
    chk("R11 sw clear ext0", irq, 0);
    wr(4, 8'h01);
    pin(0, 0); settle();
    chk("R4 edge ext0 vector", vec, 8'h03);
    do_ack();
    chk("R4 edge ext0 hw clear", got_clr, 12'h001);
    do_reti(); settle();
    chk("R4 held low no retrigger", irq, 0);
    pin(0, 1); settle();

    wr(4, 8'h05);
    pin(2, 0); settle();
    chk("R5 ext2 falling ignored in rising mode", irq, 0);
    pin(2, 1); settle();
    chk("R5 ext2 rising vector", vec, 8'h4B);
    do_ack(); do_reti();
    pin(4, 0); settle();
    chk("R5 ext4 falling ignored", irq, 0);
    pin(4, 1); settle();
    chk("R5 ext4 rising vector", vec, 8'h5B);
    do_ack(); do_reti();
    pin(3, 0); settle();
    chk("R5 ext3 falling vector", vec, 8'h53);
    do_ack(); do_reti(); pin(3, 1); settle();

    evt(7'h42); settle();
    chk("R7 pair0 beats pair3", vec, 8'h43);
    wr(2, 8'h08); settle();
    chk("R6 timer1 level1 wins", vec, 8'h1B);
    do_ack(); settle();
    chk("R8 lower level blocked", irq, 0);
    do_reti(); settle();
    chk("R12 unblocked converter", vec, 8'h43);
    do_ack(); do_reti(); wr(2, 8'h00);

    wr(0, 8'h3F);
    evt(7'h01); pin(2, 0); pin(2, 1); settle();
    chk("R3 global enable off", irq, 0);
    wr(0, 8'hBF); settle();
    chk("R7 first member of pair wins", vec, 8'h0B);
    do_ack(); do_reti(); settle();
    chk("R7 second member next", vec, 8'h4B);
    do_ack(); do_reti();

    wr(2, 8'h01); wr(3, 8'h01);
    evt(7'h02); settle(); do_ack();
    evt(7'h40); settle();
    chk("R8 level3 nests over level0", vec, 8'h43);
    do_ack();
    evt(7'h01); settle();
    chk("R8 level0 blocked while nested", irq, 0);
    do_reti(); settle();
    chk("R12 level0 still active", irq, 0);
    do_reti(); settle();
    chk("R12 timer0 after both pops", vec, 8'h0B);
    do_ack(); do_reti();
    wr(2, 8'h00); wr(3, 8'h00); settle();

    do_ack(); settle();
    evt(7'h02); settle();
    chk("R9 ack without irq ignored", vec, 8'h1B);
    do_ack(); do_reti();

    wr(1, 8'h00);
    evt(7'h40); settle();
    chk("R3 masked converter", irq, 0);
    wr(1, 8'h3F); settle();
    chk("R3 pending kept when enabled", vec, 8'h43);
    do_ack(); do_reti(); settle();

    run = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule